// File: doc/BRIEF.md
# Stoppable Clock Output Gating Controller

This block sits after the clock dividers of a system clock generator and decides, output by output, whether each already-generated clock reaches its pin. Three asynchronous active-low requests drive it: a stop for the PCI-class outputs, a stop for the processor, graphics-port and memory outputs, and a power-down request. Configuration inputs mark each output as free-running or stoppable. For each differential processor pair, a further bit chooses how the pair parks: true leg held high, or both legs low and released.

Every request is brought into the clock domain of the outputs it controls through a two-stage synchronizer. Each gate changes state only on the clock edge that leaves its output flat. A stopped output therefore ends on a full pulse and restarts with a full pulse. The power-down request counts only after two consecutive processor-clock rising edges have seen it low. It then overrides every stoppable bit.

Top module: `clk_stop_gate`

## Requirements
- R1: After reset, with every stop input high and every stoppable bit at 0, all outputs toggle and both drive flags of each processor pair are 1.
- R2: While `pci_stop_n` is low, each PCI output whose `pci_stoppable` bit is 1 stays low without toggling, and each output whose bit is 0 keeps toggling. Stopped outputs toggle again after the input returns high.
- R3: While `clk_stop_n` is low, graphics outputs with their bit set stay low. Memory pair 0 follows `ddr0_stoppable`, and pairs 1 and up follow `ddr_rest_stoppable`. A stopped memory pair holds both legs low. Outputs whose bit is 0 keep toggling.
- R4: A stopped processor pair with `cpu_park_low` at 0 holds its true leg high and driven (`cpu_t_drv`=1), and its complement leg low and undriven (`cpu_c_drv`=0).
- R5: A stopped processor pair with `cpu_park_low` at 1 holds both legs low, and both drive flags are 0.
- R6: After `clk_stop_n` returns high, the complement leg of a stopped processor pair rises again no sooner than 2 and no later than 6 processor-clock periods later. In the both-low mode, `cpu_t_drv` returns to 1 within 6 periods.
- R7: Once `pd_n` has been seen low on two consecutive processor-clock rising edges, every non-processor output stays low and every processor pair parks according to R4/R5, whatever the stoppable bits say. All outputs resume once `pd_n` is high again.
- R8: A low pulse on `pd_n` that covers only one processor-clock rising edge has no effect, and all outputs keep toggling.
- R9: No gated output ever shows a high or low pulse shorter than half the period of its source clock, including on entry to and exit from the stopped state.
- R10: `clk_stop_n` has no effect on PCI outputs, and `pci_stop_n` has no effect on processor, graphics or memory outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, applied in every clock domain |
| cpu_clk | input | 1 | Source clock for processor pairs and power-down qualification |
| ddr_clk | input | 1 | Source clock for memory pairs |
| agp_clk | input | 1 | Source clock for graphics outputs |
| pci_clk | input | 1 | Source clock for PCI outputs |
| pci_stop_n | input | 1 | Asynchronous active-low PCI-class stop |
| clk_stop_n | input | 1 | Asynchronous active-low processor/graphics/memory stop |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| pci_stoppable | input | N_PCI | Per PCI output: 1 stoppable, 0 free-running |
| agp_stoppable | input | N_AGP | Per graphics output: 1 stoppable |
| ddr0_stoppable | input | 1 | Memory pair 0: 1 stoppable |
| ddr_rest_stoppable | input | 1 | Memory pairs 1 and up: 1 stoppable |
| cpu_stoppable | input | N_CPU | Per processor pair: 1 stoppable |
| cpu_park_low | input | N_CPU | Per processor pair: 0 true-high park, 1 both-low undriven park |
| pci_o | output | N_PCI | Gated PCI clocks |
| agp_o | output | N_AGP | Gated graphics clocks |
| ddr_t_o | output | N_DDR | Gated memory true legs |
| ddr_c_o | output | N_DDR | Gated memory complement legs |
| cpu_t_o | output | N_CPU | Gated processor true legs |
| cpu_c_o | output | N_CPU | Gated processor complement legs |
| cpu_t_drv | output | N_CPU | Drive enable of each processor true leg |
| cpu_c_drv | output | N_CPU | Drive enable of each processor complement leg |

## Verification
The stoppable masks are exercised in several patterns. An alternating PCI mask shows that each output follows its own bit. A split memory setting (pair 0 against the rest, set one way and then the reverse) separates the single-pair bit from the group bit. Mixed processor polarities, tried both ways round, show that each pair takes its own parked state. A one-edge power-down pulse against a held one shows the two-sample qualification. Power-down with every stoppable bit cleared shows that it overrides the masks. A pulse-width monitor on every output catches runt pulses at each stop and restart.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Depth of every request synchronizer.
  localparam int unsigned SYNC_DEPTH = 2;

  // An output halts on power-down, or on its class stop when marked stoppable.
  function automatic logic halt_of(input logic stop_req, input logic stoppable,
                                   input logic pd_req);
    return pd_req | (stop_req & stoppable);
  endfunction

endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[TOP-1:0], d};
  end

  assign q = shreg[TOP];
endmodule

// File: rtl/ckg_gate_lo.sv
module ckg_gate_lo (
  input  logic src,
  input  logic rst,
  input  logic halt,
  output logic gclk
);
  logic run_q;

  // Enable moves only while src is low, so the AND never cuts a pulse.
  always_ff @(negedge src) begin
    if (rst) run_q <= 1'b1;
    else     run_q <= ~halt;
  end

  assign gclk = src & run_q;

  // R3
  parked_low_chk: assert property (@(negedge src) disable iff (rst)
    $past(halt && !rst) |-> !gclk);

  // R1
  running_high_chk: assert property (@(negedge src) disable iff (rst)
    $past(!halt && !rst) |-> gclk);
endmodule

// File: rtl/ckg_cpu_pair.sv
module ckg_cpu_pair (
  input  logic src,
  input  logic rst,
  input  logic halt,
  input  logic park_low,
  output logic t_o,
  output logic c_o,
  output logic t_drv,
  output logic c_drv
);
  logic t_hold_q;  // rising-edge: holds true leg high in high-park mode
  logic c_run_q;   // rising-edge: complement enable (complement is low then)
  logic t_run_q;   // falling-edge: true enable for low-park mode

  always_ff @(posedge src) begin
    if (rst) begin
      t_hold_q <= 1'b0;
      c_run_q  <= 1'b1;
    end else begin
      t_hold_q <= halt & ~park_low;
      c_run_q  <= ~halt;
    end
  end

  always_ff @(negedge src) begin
    if (rst) t_run_q <= 1'b1;
    else     t_run_q <= ~(halt & park_low);
  end

  assign t_o   = (src & t_run_q) | t_hold_q;
  assign c_o   = ~src & c_run_q;
  assign t_drv = t_run_q;
  assign c_drv = c_run_q;

  // R4
  park_high_chk: assert property (@(posedge src) disable iff (rst)
    $past(halt && !park_low && !rst) |-> (t_o && !c_o && !c_drv));

  // R5
  park_low_true_chk: assert property (@(negedge src) disable iff (rst)
    $past(halt && park_low && !rst) |-> (!t_o && !t_drv));

  // R5
  park_low_comp_chk: assert property (@(posedge src) disable iff (rst)
    $past(halt && park_low && !rst) |-> (!c_o && !c_drv));
endmodule

// File: rtl/ckg_pd_qual.sv
module ckg_pd_qual #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  output logic pd_acc
);
  logic req_s;
  logic req_prev_q;
  logic acc_q;

  ckg_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(~pd_n), .q(req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev_q <= 1'b0;
      acc_q      <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      acc_q      <= req_s & req_prev_q;
    end
  end

  assign pd_acc = acc_q;

  // R7
  two_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_acc) |-> ($past(req_s) && $past(req_s, 2)));
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clkgate_pkg::*;
#(
  parameter int unsigned N_PCI = 7,
  parameter int unsigned N_AGP = 2,
  parameter int unsigned N_DDR = 7,
  parameter int unsigned N_CPU = 2
) (
  input  logic             rst,
  input  logic             cpu_clk,
  input  logic             ddr_clk,
  input  logic             agp_clk,
  input  logic             pci_clk,
  input  logic             pci_stop_n,
  input  logic             clk_stop_n,
  input  logic             pd_n,
  input  logic [N_PCI-1:0] pci_stoppable,
  input  logic [N_AGP-1:0] agp_stoppable,
  input  logic             ddr0_stoppable,
  input  logic             ddr_rest_stoppable,
  input  logic [N_CPU-1:0] cpu_stoppable,
  input  logic [N_CPU-1:0] cpu_park_low,
  output logic [N_PCI-1:0] pci_o,
  output logic [N_AGP-1:0] agp_o,
  output logic [N_DDR-1:0] ddr_t_o,
  output logic [N_DDR-1:0] ddr_c_o,
  output logic [N_CPU-1:0] cpu_t_o,
  output logic [N_CPU-1:0] cpu_c_o,
  output logic [N_CPU-1:0] cpu_t_drv,
  output logic [N_CPU-1:0] cpu_c_drv
);
  localparam int unsigned DDR_REST = N_DDR - 1;

  // ---------------- processor domain ----------------
  logic pd_acc;
  logic cpu_stop_s;

  ckg_pd_qual #(.STAGES(SYNC_DEPTH)) u_pd (
    .clk(cpu_clk), .rst(rst), .pd_n(pd_n), .pd_acc(pd_acc)
  );

  ckg_sync #(.STAGES(SYNC_DEPTH)) u_cpu_stop (
    .clk(cpu_clk), .rst(rst), .d(~clk_stop_n), .q(cpu_stop_s)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    ckg_cpu_pair u_pair (
      .src      (cpu_clk),
      .rst      (rst),
      .halt     (halt_of(cpu_stop_s, cpu_stoppable[g], pd_acc)),
      .park_low (cpu_park_low[g]),
      .t_o      (cpu_t_o[g]),
      .c_o      (cpu_c_o[g]),
      .t_drv    (cpu_t_drv[g]),
      .c_drv    (cpu_c_drv[g])
    );
  end

  // ---------------- PCI domain ----------------
  logic pci_stop_s;
  logic pci_pd_s;

  ckg_sync #(.STAGES(SYNC_DEPTH)) u_pci_stop (
    .clk(pci_clk), .rst(rst), .d(~pci_stop_n), .q(pci_stop_s)
  );
  ckg_sync #(.STAGES(SYNC_DEPTH)) u_pci_pd (
    .clk(pci_clk), .rst(rst), .d(pd_acc), .q(pci_pd_s)
  );

  for (genvar g = 0; g < N_PCI; g++) begin : g_pci
    ckg_gate_lo u_gate (
      .src  (pci_clk),
      .rst  (rst),
      .halt (halt_of(pci_stop_s, pci_stoppable[g], pci_pd_s)),
      .gclk (pci_o[g])
    );
  end

  // ---------------- graphics domain ----------------
  logic agp_stop_s;
  logic agp_pd_s;

  ckg_sync #(.STAGES(SYNC_DEPTH)) u_agp_stop (
    .clk(agp_clk), .rst(rst), .d(~clk_stop_n), .q(agp_stop_s)
  );
  ckg_sync #(.STAGES(SYNC_DEPTH)) u_agp_pd (
    .clk(agp_clk), .rst(rst), .d(pd_acc), .q(agp_pd_s)
  );

  for (genvar g = 0; g < N_AGP; g++) begin : g_agp
    ckg_gate_lo u_gate (
      .src  (agp_clk),
      .rst  (rst),
      .halt (halt_of(agp_stop_s, agp_stoppable[g], agp_pd_s)),
      .gclk (agp_o[g])
    );
  end

  // ---------------- memory domain ----------------
  logic             ddr_stop_s;
  logic             ddr_pd_s;
  logic             ddr_clk_n;
  logic [N_DDR-1:0] ddr_sel;

  assign ddr_clk_n = ~ddr_clk;
  assign ddr_sel   = {{DDR_REST{ddr_rest_stoppable}}, ddr0_stoppable};

  ckg_sync #(.STAGES(SYNC_DEPTH)) u_ddr_stop (
    .clk(ddr_clk), .rst(rst), .d(~clk_stop_n), .q(ddr_stop_s)
  );
  ckg_sync #(.STAGES(SYNC_DEPTH)) u_ddr_pd (
    .clk(ddr_clk), .rst(rst), .d(pd_acc), .q(ddr_pd_s)
  );

  for (genvar g = 0; g < N_DDR; g++) begin : g_ddr
    logic halt_g;
    assign halt_g = halt_of(ddr_stop_s, ddr_sel[g], ddr_pd_s);

    ckg_gate_lo u_true (
      .src(ddr_clk), .rst(rst), .halt(halt_g), .gclk(ddr_t_o[g])
    );
    ckg_gate_lo u_comp (
      .src(ddr_clk_n), .rst(rst), .halt(halt_g), .gclk(ddr_c_o[g])
    );
  end
endmodule

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/100ps
module tb_clk_stop_gate;
  localparam int NP = 7, NA = 2, ND = 7, NC = 2;
  localparam int NW = NP + NA + 2*ND + 2*NC;

  logic cpu_clk = 0, ddr_clk = 0, agp_clk = 0, pci_clk = 0;
  logic rst;
  logic pci_stop_n, clk_stop_n, pd_n;
  logic [NP-1:0] pci_stoppable;
  logic [NA-1:0] agp_stoppable;
  logic ddr0_stoppable, ddr_rest_stoppable;
  logic [NC-1:0] cpu_stoppable, cpu_park_low;
  logic [NP-1:0] pci_o;
  logic [NA-1:0] agp_o;
  logic [ND-1:0] ddr_t_o, ddr_c_o;
  logic [NC-1:0] cpu_t_o, cpu_c_o, cpu_t_drv, cpu_c_drv;

  always #2.5 cpu_clk = ~cpu_clk;   // 200 MHz
  always #5   ddr_clk = ~ddr_clk;
  always #7.5 agp_clk = ~agp_clk;
  always #15  pci_clk = ~pci_clk;

  clk_stop_gate #(.N_PCI(NP), .N_AGP(NA), .N_DDR(ND), .N_CPU(NC)) dut (
    .rst(rst), .cpu_clk(cpu_clk), .ddr_clk(ddr_clk), .agp_clk(agp_clk),
    .pci_clk(pci_clk), .pci_stop_n(pci_stop_n), .clk_stop_n(clk_stop_n),
    .pd_n(pd_n), .pci_stoppable(pci_stoppable), .agp_stoppable(agp_stoppable),
    .ddr0_stoppable(ddr0_stoppable), .ddr_rest_stoppable(ddr_rest_stoppable),
    .cpu_stoppable(cpu_stoppable), .cpu_park_low(cpu_park_low),
    .pci_o(pci_o), .agp_o(agp_o), .ddr_t_o(ddr_t_o), .ddr_c_o(ddr_c_o),
    .cpu_t_o(cpu_t_o), .cpu_c_o(cpu_c_o), .cpu_t_drv(cpu_t_drv),
    .cpu_c_drv(cpu_c_drv)
  );

  int checks = 0, errors = 0, runts = 0;
  bit mon_on = 0;

  // ---------- edge counting and pulse-width monitor (R9) ----------
  logic [NW-1:0] allv, prev;
  int  tog [NW];
  real last[NW];
  assign allv = {cpu_c_o, cpu_t_o, ddr_c_o, ddr_t_o, agp_o, pci_o};

  function automatic real thr_of(int b);
    if (b < NP)           return 14.9;
    if (b < NP + NA)      return 7.4;
    if (b < NP + NA + 2*ND) return 4.9;
    return 2.4;
  endfunction

  initial for (int b = 0; b < NW; b++) begin tog[b] = 0; last[b] = -1.0; end

  always @(allv) begin
    if (mon_on) begin
      for (int b = 0; b < NW; b++) begin
        if (allv[b] !== prev[b]) begin
          tog[b]++;
          if (last[b] >= 0.0 && ($realtime - last[b]) < thr_of(b)) runts++;
          last[b] = $realtime;
        end
      end
    end
    prev = allv;
  end

  // ---------- observation snapshot ----------
  logic [NP-1:0] o_pci_act, o_pci_lvl;
  logic [NA-1:0] o_agp_act, o_agp_lvl;
  logic [ND-1:0] o_ddr_act, o_ddr_lvl;
  logic [NC-1:0] o_cpu_act, o_tl, o_cl, o_td, o_cd;

  task automatic observe();
    int start[NW];
    logic [NW-1:0] act;
    for (int b = 0; b < NW; b++) start[b] = tog[b];
    #200.3;
    for (int b = 0; b < NW; b++) act[b] = (tog[b] != start[b]);
    o_pci_act = act[NP-1:0];
    o_agp_act = act[NP+NA-1:NP];
    o_ddr_act = act[NP+NA+ND-1:NP+NA] | act[NP+NA+2*ND-1:NP+NA+ND];
    o_cpu_act = act[NP+NA+2*ND+NC-1:NP+NA+2*ND] | act[NW-1:NP+NA+2*ND+NC];
    o_pci_lvl = pci_o;
    o_agp_lvl = agp_o;
    o_ddr_lvl = ddr_t_o | ddr_c_o;
    o_tl = cpu_t_o; o_cl = cpu_c_o; o_td = cpu_t_drv; o_cd = cpu_c_drv;
  endtask

  // ---------- scoreboard ----------
  typedef struct {
    string ta;  // tag for PCI checks
    string tb;  // tag for graphics / memory checks
    string tc;  // tag for processor checks ("" = by polarity)
    logic [NP-1:0] pci;
    logic [NA-1:0] agp;
    logic [ND-1:0] ddr;
    logic [NC-1:0] cpu;
    logic [NC-1:0] t_hi;
  } exp_t;

  exp_t q[$];

  task automatic chk(bit ok, string tag, string what, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  task automatic expect_push(string ta, string tb, string tc, logic [NP-1:0] p,
                             logic [NA-1:0] a, logic [ND-1:0] d,
                             logic [NC-1:0] c, logic [NC-1:0] hi);
    exp_t e;
    observe();
    e.ta = ta; e.tb = tb; e.tc = tc;
    e.pci = p; e.agp = a; e.ddr = d; e.cpu = c; e.t_hi = hi;
    q.push_back(e);
    #1;
  endtask

  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      chk(o_pci_act == e.pci && (o_pci_lvl & ~e.pci) == '0, e.ta, "pci activity",
          32'(o_pci_act), 32'(e.pci));
      chk(o_agp_act == e.agp && (o_agp_lvl & ~e.agp) == '0, e.tb, "agp activity",
          32'(o_agp_act), 32'(e.agp));
      chk(o_ddr_act == e.ddr && (o_ddr_lvl & ~e.ddr) == '0, e.tb, "ddr activity",
          32'(o_ddr_act), 32'(e.ddr));
      for (int i = 0; i < NC; i++) begin
        if (e.cpu[i])
          chk(o_cpu_act[i] && o_td[i] && o_cd[i], (e.tc == "") ? e.tb : e.tc,
              "cpu pair running {act,tdrv,cdrv}",
              32'({o_cpu_act[i], o_td[i], o_cd[i]}), 32'h7);
        else
          chk({o_cpu_act[i], o_tl[i], o_td[i], o_cl[i], o_cd[i]} ==
              {1'b0, e.t_hi[i], e.t_hi[i], 2'b00},
              (e.tc != "") ? e.tc : (e.t_hi[i] ? "R4" : "R5"),
              "cpu pair parked {act,t,tdrv,c,cdrv}",
              32'({o_cpu_act[i], o_tl[i], o_td[i], o_cl[i], o_cd[i]}),
              32'({1'b0, e.t_hi[i], e.t_hi[i], 2'b00}));
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  // ---------- driver ----------
  localparam logic [NP-1:0] ALLP = '1;
  localparam logic [NA-1:0] ALLA = '1;
  localparam logic [ND-1:0] ALLD = '1;
  localparam logic [NC-1:0] ALLC = '1;

  initial begin
    real t0, t_c, t_d;
    rst = 1; pci_stop_n = 1; clk_stop_n = 1; pd_n = 1;
    pci_stoppable = '0; agp_stoppable = '0; ddr0_stoppable = 0;
    ddr_rest_stoppable = 0; cpu_stoppable = '0; cpu_park_low = '0;
    #100.2 rst = 0;
    #50 mon_on = 1;

    // R1: reset state, everything running and driven
    expect_push("R1", "R1", "R1", ALLP, ALLA, ALLD, ALLC, '0);

    // R2 / R10: alternating PCI mask, others untouched
    pci_stoppable = 7'b1010101;
    pci_stop_n = 0; #300;
    expect_push("R2", "R10", "R10", ~7'b1010101, ALLA, ALLD, ALLC, '0);
    pci_stop_n = 1; #300;
    expect_push("R2", "R10", "R10", ALLP, ALLA, ALLD, ALLC, '0);

    // R3 / R4 / R5 / R10: pair0 high park, pair1 low park, ddr pair0 only
    cpu_stoppable = 2'b11; cpu_park_low = 2'b10; agp_stoppable = 2'b01;
    ddr0_stoppable = 1; ddr_rest_stoppable = 0;
    clk_stop_n = 0; #300;
    expect_push("R10", "R3", "", ALLP, 2'b10, 7'b1111110, 2'b00, 2'b01);

    // R6: restart latency
    #0.7;
    t0 = $realtime; t_c = -1.0; t_d = -1.0;
    clk_stop_n = 1;
    fork
      begin @(posedge cpu_c_o[0]); t_c = $realtime; end
      begin @(posedge cpu_t_drv[1]); t_d = $realtime; end
    join
    chk((t_c - t0) >= 10.0 && (t_c - t0) <= 30.0, "R6", "complement restart ns",
        32'($rtoi(t_c - t0)), 32'd30);
    chk((t_d - t0) <= 30.0, "R6", "true drive restored ns",
        32'($rtoi(t_d - t0)), 32'd30);
    #300;
    expect_push("R6", "R6", "R6", ALLP, ALLA, ALLD, ALLC, '0);

    // R3 / R4 / R5: reversed settings, group bit for ddr pairs 1..N-1
    cpu_stoppable = 2'b01; cpu_park_low = 2'b01; agp_stoppable = 2'b10;
    ddr0_stoppable = 0; ddr_rest_stoppable = 1;
    clk_stop_n = 0; #300;
    expect_push("R10", "R3", "", ALLP, 2'b01, 7'b0000001, 2'b10, 2'b00);
    clk_stop_n = 1; #300;
    expect_push("R3", "R3", "R3", ALLP, ALLA, ALLD, ALLC, '0);

    // R8: power-down low across one processor rising edge only
    @(posedge cpu_clk); #1 pd_n = 0; #5 pd_n = 1;
    #300;
    expect_push("R8", "R8", "R8", ALLP, ALLA, ALLD, ALLC, '0);

    // R7: held power-down overrides cleared stoppable bits
    pci_stoppable = '0; agp_stoppable = '0; ddr0_stoppable = 0;
    ddr_rest_stoppable = 0; cpu_stoppable = '0; cpu_park_low = 2'b01;
    pd_n = 0; #400;
    expect_push("R7", "R7", "R7", '0, '0, '0, 2'b00, 2'b10);
    pd_n = 1; #400;
    expect_push("R7", "R7", "R7", ALLP, ALLA, ALLD, ALLC, '0);

    wait (q.size() == 0);
    #1;
    // R9: no runt pulses across every stop and restart above
    chk(runts == 0, "R9", "runt pulse count", 32'(runts), 32'd0);
    finish_run();
  end
endmodule